// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by counting ticks of a slow, low-speed clock. Its mode is fixed by an 8-bit configuration byte that the block latches on the first cycle after reset and again after each reset request it raises. Software keeps the system alive by writing the restart key 0xAC to the enable register while the counter sits inside a permitted window near the end of its period. A write with any other value, a key written too early, or a count that runs to the selected limit all raise a one-cycle reset request.

An optional warning interrupt pulses once when the count reaches three quarters of the limit, so software can restart the timer before overflow. The block can also stop counting during standby, or ignore standby, depending on the configuration. Reading the enable register always returns a fixed status byte and has no effect on the count.

Top module: `win_watchdog`

## Requirements
- R1: While reset is held and after it is released, `rst_req` and `warn_irq` are 0, and `rd_data` always reads 0x9A.
- R2: `cfg_byte` is latched on the first clock edge with `rst_n` high and again on the edge after every `rst_req` pulse. Its fields are: bit 7 enables the warning, bits 6:5 select the window, bit 4 enables counting, bits 3:1 select the limit, and bit 0 = 1 keeps counting during standby. Counting starts on the edge after the latch.
- R3: When the count reaches the limit, `rst_req` pulses for exactly one cycle. The limit is counted in `slow_tick` cycles, and select values 0 to 7 give 2^7, 2^8, 2^9, 2^10, 2^12, 2^14, 2^15 and 2^17 ticks.
- R4: With bit 7 set, `warn_irq` pulses for one cycle when the count reaches 3/4 of the limit. With bit 7 clear, it never pulses.
- R5: Writing 0xAC while the window is open clears the count to zero, and counting restarts from there. No reset request is raised.
- R6: Writing any value other than 0xAC raises `rst_req` on the cycle after the write, whatever the window state.
- R7: The window opens when the count, taken before the write edge, is at least the limit minus the open length. The open length is the final 25%, 50%, 75% or 100% of the limit for window codes 0 to 3. Writing 0xAC while the window is closed raises `rst_req` on the cycle after the write.
- R8: With `standby` high and bit 0 clear, the count holds its value. With bit 0 set, standby has no effect on counting.
- R9: With bit 4 clear, the count stays at zero, no reset request is raised and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable for each low-speed clock period |
| standby | input | 1 | System is in a standby mode |
| cfg_byte | input | 8 | Configuration byte, latched as described in R2 |
| wr_en | input | 1 | Write strobe for the enable register |
| wr_data | input | 8 | Write data for the enable register |
| rd_data | output | 8 | Read value of the enable register (fixed 0x9A) |
| rst_req | output | 1 | One-cycle reset request |
| warn_irq | output | 1 | One-cycle early-warning interrupt |

## Verification
Each result is registered once. A bad or early write shows `rst_req` one edge after the write edge. From the latch edge, or from an accepted key write, overflow shows at edge +limit and the warning at edge +3/4·limit, plus one edge for every tick that standby held back. The bench counts edges. For each stimulus it queues the exact edge on which every pulse is due, and it compares outputs at the falling edge that follows. A pulse on any other edge, or a queued pulse that never arrives, is reported.

// File: rtl/win_watchdog_pkg.sv
package win_watchdog_pkg;

   localparam logic [7:0] WDW_KEY    = 8'hAC;
   localparam logic [7:0] WDW_STATUS = 8'h9A;
   localparam int unsigned WDW_SPANS = 8;

   typedef struct packed {
      logic       warn_en;
      logic [1:0] win_sel;
      logic       run_en;
      logic [2:0] span_sel;
      logic       stby_run;
   } wdw_cfg_t;

   // exponent of the overflow limit for each select code
   function automatic int unsigned span_exp(input logic [2:0] sel);
      case (sel)
         3'd0:    span_exp = 7;
         3'd1:    span_exp = 8;
         3'd2:    span_exp = 9;
         3'd3:    span_exp = 10;
         3'd4:    span_exp = 12;
         3'd5:    span_exp = 14;
         3'd6:    span_exp = 15;
         default: span_exp = 17;
      endcase
   endfunction

endpackage

// File: rtl/wdw_cfg_hold.sv
module wdw_cfg_hold
   import win_watchdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] cfg_byte,
   input  logic       reload,
   output wdw_cfg_t   cfg,
   output logic       loading
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loading <= 1'b1;
         cfg     <= '0;
      end else if (reload) begin
         loading <= 1'b1;
      end else if (loading) begin
         cfg     <= wdw_cfg_t'(cfg_byte);
         loading <= 1'b0;
      end
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !loading |=> $stable(cfg)) else $error("cfg changed outside load"); // R2

endmodule

// File: rtl/wdw_thresholds.sv
module wdw_thresholds
   import win_watchdog_pkg::*;
#(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [2:0]       span_sel,
   input  logic [1:0]       win_sel,
   output logic             at_last,
   output logic             at_warn,
   output logic             win_open
);

   logic [CNT_W-1:0] lim_tab [WDW_SPANS];

   for (genvar g = 0; g < WDW_SPANS; g++) begin : g_lim
      assign lim_tab[g] = CNT_W'(1) << span_exp(3'(g));
   end

   logic [CNT_W-1:0] limit, quarter, warn_thr, open_len;

   always_comb begin
      limit    = lim_tab[span_sel];
      quarter  = limit >> 2;
      warn_thr = limit - quarter;
      open_len = quarter * ({{(CNT_W-2){1'b0}}, win_sel} + CNT_W'(1));
      at_last  = (cnt == limit - CNT_W'(1));
      at_warn  = (cnt == warn_thr - CNT_W'(1));
      win_open = (cnt >= limit - open_len);
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < limit) else $error("count reached limit"); // R3

endmodule

// File: rtl/wdw_counter.sv
module wdw_counter #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (step)  cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/wdw_key_check.sv
module wdw_key_check
   import win_watchdog_pkg::*;
(
   input  logic       armed,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       win_open,
   output logic       key_good,
   output logic       key_fault
);

   logic is_key;

   always_comb begin
      is_key    = (wr_data == WDW_KEY);
      key_good  = armed && wr_en && is_key && win_open;
      key_fault = armed && wr_en && (!is_key || !win_open);
   end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
   import win_watchdog_pkg::*;
#(
   parameter int unsigned CNT_W = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slow_tick,
   input  logic       standby,
   input  logic [7:0] cfg_byte,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       rst_req,
   output logic       warn_irq
);

   if (CNT_W < 18) begin : g_width_bad
      $error("CNT_W must hold the largest limit of 2^17");
   end

   wdw_cfg_t         cfg;
   logic             loading, armed, step, clr, trip, warn_hit;
   logic             at_last, at_warn, win_open, key_good, key_fault;
   logic [CNT_W-1:0] cnt;

   wdw_cfg_hold u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte),
      .reload(trip), .cfg(cfg), .loading(loading)
   );

   wdw_thresholds #(.CNT_W(CNT_W)) u_thr (
      .clk(clk), .rst_n(rst_n), .cnt(cnt),
      .span_sel(cfg.span_sel), .win_sel(cfg.win_sel),
      .at_last(at_last), .at_warn(at_warn), .win_open(win_open)
   );

   wdw_key_check u_key (
      .armed(armed), .wr_en(wr_en), .wr_data(wr_data),
      .win_open(win_open), .key_good(key_good), .key_fault(key_fault)
   );

   always_comb begin
      armed    = !loading && cfg.run_en;
      step     = armed && slow_tick && (!standby || cfg.stby_run);
      trip     = (step && at_last) || key_fault;
      clr      = trip || key_good || !armed;
      warn_hit = step && at_warn && !trip && !key_good && cfg.warn_en;
   end

   wdw_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .clr(clr), .cnt(cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         warn_irq <= 1'b0;
      end else begin
         rst_req  <= trip;
         warn_irq <= warn_hit;
      end
   end

   assign rd_data = WDW_STATUS;

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req) else $error("reset request too long"); // R3
   AST_WARN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      warn_irq |=> !warn_irq) else $error("warning too long"); // R4
   AST_WARN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      warn_irq |-> cfg.warn_en) else $error("warning while disabled"); // R4
   AST_REQ_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (loading && cnt == '0)) else $error("no restart after request"); // R2
   AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && !cfg.stby_run && !clr) |=> $stable(cnt)) else $error("count moved in standby"); // R8
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.run_en && !loading) |-> cnt == '0) else $error("count while disabled"); // R9
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.run_en && !loading) |=> !rst_req) else $error("request while disabled"); // R9

endmodule

// File: tb/win_watchdog_tb_top.sv
`timescale 1ns/1ps
module win_watchdog_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slow_tick = 1'b1;
   logic       standby = 1'b0;
   logic [7:0] cfg_byte = 8'hF0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       rst_req, warn_irq;

   always #4 clk = ~clk;

   win_watchdog dut_i (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .standby(standby),
      .cfg_byte(cfg_byte), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .rst_req(rst_req), .warn_irq(warn_irq)
   );

   typedef struct {
      int    at;
      bit    is_rst;
      string req;
   } ev_t;

   ev_t q[$];
   int  cyc = 0;
   int  checks = 0;
   int  errors = 0;
   bit  done = 0;
   int  org;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic expect_ev(int at, bit is_rst, string req);
      ev_t e;
      e.at = at; e.is_rst = is_rst; e.req = req;
      q.push_back(e);
   endtask

   task automatic wait_cyc(int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic wr(int at_edge, logic [7:0] v);
      wait_cyc(at_edge - 1);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // after the reset request seen on edge k, load the next byte
   task automatic next_cfg(int k, logic [7:0] b);
      wait_cyc(k);
      cfg_byte = b;
      org = k + 1;
   endtask

   task automatic match(bit is_rst);
      checks++;
      if (q.size() > 0 && q[0].at == cyc && q[0].is_rst == is_rst) begin
         void'(q.pop_front());
      end else begin
         errors++;
         if (q.size() > 0)
            $display("FAIL %s: unexpected %s at edge %0d, expected %s at edge %0d",
                     q[0].req, is_rst ? "rst_req" : "warn_irq", cyc,
                     q[0].is_rst ? "rst_req" : "warn_irq", q[0].at);
         else
            $display("FAIL R3 R4 R9: unexpected %s at edge %0d, expected none",
                     is_rst ? "rst_req" : "warn_irq", cyc);
      end
   endtask

   // monitor: compares outputs with the scoreboard away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (q.size() > 0 && q[0].at < cyc) begin
            checks++; errors++;
            $display("FAIL %s: missing pulse, actual none expected edge %0d", q[0].req, q[0].at);
            void'(q.pop_front());
         end
         if (warn_irq) match(1'b0);
         if (rst_req)  match(1'b1);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int w;
      repeat (3) @(negedge clk);
      chk(rst_req == 1'b0, "R1", rst_req, 0);
      chk(warn_irq == 1'b0, "R1", warn_irq, 0);
      chk(rd_data == 8'h9A, "R1", rd_data, 8'h9A);
      // 0xF0: warning on, full window, run, limit 128
      rst_n = 1'b1;
      org = cyc + 1;
      expect_ev(org + 96, 1'b0, "R4");
      expect_ev(org + 128, 1'b1, "R3 R2");
      // 0x10: 25% window, no warning
      next_cfg(org + 128, 8'h10);
      w = org + 50;
      expect_ev(w, 1'b1, "R7 early key");
      wr(w, 8'hAC);
      next_cfg(w, 8'h10);
      // key at count 96 is accepted, key at count 95 after the clear is not
      w = org + 97;
      wr(w, 8'hAC);
      expect_ev(w + 96, 1'b1, "R5 R7 window edge");
      wr(w + 96, 8'hAC);
      // 0xB2: warning on, 50% window, limit 256
      next_cfg(w + 96, 8'hB2);
      expect_ev(org + 192, 1'b0, "R4 limit 256");
      expect_ev(org + 256, 1'b1, "R3 limit 256");
      next_cfg(org + 256, 8'h10);
      // wrong value inside the open window
      w = org + 110;
      expect_ev(w, 1'b1, "R6 wrong value");
      wr(w, 8'hAD);
      // 0x11: standby ignored
      next_cfg(w, 8'h11);
      chk(rd_data == 8'h9A, "R1", rd_data, 8'h9A);
      expect_ev(org + 128, 1'b1, "R8 standby ignored");
      wait_cyc(org + 19); standby = 1'b1;
      wait_cyc(org + 59); standby = 1'b0;
      // 0x10: standby holds for 40 ticks
      next_cfg(org + 128, 8'h10);
      expect_ev(org + 168, 1'b1, "R8 standby hold");
      wait_cyc(org + 19); standby = 1'b1;
      wait_cyc(org + 59); standby = 1'b0;
      // 0x00: disabled, writes ignored
      next_cfg(org + 168, 8'h00);
      wr(org + 150, 8'h55);
      wr(org + 200, 8'hAC);
      wait_cyc(org + 300);
      chk(rst_req == 1'b0, "R9", rst_req, 0);
      chk(q.size() == 0, "R9", q.size(), 0);
      // hardware reset, then 0x90: warning on, 25% window, limit 128
      rst_n = 1'b0;
      cfg_byte = 8'h90;
      repeat (2) @(negedge clk);
      chk(rst_req == 1'b0, "R1", rst_req, 0);
      chk(warn_irq == 1'b0, "R1", warn_irq, 0);
      rst_n = 1'b1;
      org = cyc + 1;
      expect_ev(org + 96, 1'b0, "R4 R2 after reset");
      expect_ev(org + 128, 1'b1, "R3 R2 after reset");
      wait_cyc(org + 135);
      chk(q.size() == 0, "R3", q.size(), 0);
      finish_run();
   end

endmodule